// File: doc/BRIEF.md
# Host Parallel Port for a MIDI Byte Path

This block connects an 8-bit host processor bus to a chip's internal MIDI byte stream. The host talks to it through active-low chip select, read strobe and write strobe, one address line and an 8-bit data bus. Address 0 selects the data register. Address 1 selects the control register on writes and the status register on reads. Every bus pin passes through a two-flop synchroniser into the single system clock domain, and strobe edges are found on the synchronised copies.

After reset, received MIDI bytes go straight to the internal synthesizer. A control write of 3Fh hands the byte stream to the host instead. Each received byte is then held in the data register, and an interrupt line stays high until the host reads the byte. A control write of FFh gives the stream back to the synthesizer. Host data writes go to an internal output path.

The block guards against two kinds of host misbehaviour. A byte left unread for a parameterised number of cycles shuts the port down. Once shut, the port forces the interrupt low and returns 00h on data reads, and only FFh followed by 3Fh opens it again. Writes that come sooner than a minimum spacing after the last accepted write are flagged and dropped.

Top module: `midi_host_port`

## Requirements
- R1: After reset, irq is 0, uart_mode is 0, bus_doe is 0 and a status read returns BFh.
- R2: A control write (A=1) of 3Fh in synthesizer mode sets uart_mode to 1. A control write of FFh in host mode sets it back to 0.
- R3: While uart_mode is 0, each rx_valid cycle shows in the same cycle on synth_valid, with synth_byte equal to rx_byte. While uart_mode is 1, synth_valid stays 0.
- R4: In host mode, a received byte raises irq on the next clock. A data read (A=0) then returns that byte, and status reads 3Fh, where bit 7 low means a byte is ready.
- R5: The rising read strobe of a data read, with chip select low, consumes the byte: irq falls and status bit 7 returns to 1. A status read consumes nothing.
- R6: A data write (A=0) is captured on the rising write strobe while chip select is low. It produces one hdata_valid pulse with hdata_byte equal to the bus value.
- R7: Strobes with chip select high have no effect: no mode change and no hdata_valid pulse.
- R8: A byte pending for TIMEOUT_CYC cycles shuts the port down. irq goes to 0, uart_mode goes to 0, data reads return 00h, status reads BFh, and host data writes are not forwarded.
- R9: A shut port ignores 3Fh alone. After FFh it is in synthesizer mode, and a following 3Fh returns it to host mode with the interrupt path working.
- R10: A write that comes within MIN_GAP cycles of the last accepted write pulses wr_too_fast and is dropped. Status bit 6 reads 1 during the spacing window and 0 outside it.
- R11: bus_doe is 1 only while the synchronised chip select and read strobe are both low, so never while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_a | input | 1 | Register select: 0 data, 1 control/status |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_din | input | 8 | Bus value driven by the host |
| bus_dout | output | 8 | Value presented to the host on reads |
| bus_doe | output | 1 | Output enable for bus_dout |
| irq | output | 1 | High while a received byte waits for the host |
| rx_valid | input | 1 | Received MIDI byte strobe |
| rx_byte | input | 8 | Received MIDI byte |
| synth_valid | output | 1 | Byte strobe towards the synthesizer |
| synth_byte | output | 8 | Byte towards the synthesizer |
| hdata_valid | output | 1 | Host data write pulse |
| hdata_byte | output | 8 | Host data write value |
| uart_mode | output | 1 | 1 while received bytes go to the host |
| wr_too_fast | output | 1 | Pulse on a write that broke the minimum spacing |

## Verification
A wrong mode state shows at once on synth_valid, in the same cycle as the next rx_valid, and on uart_mode. A stuck or stale pending flag shows on irq one clock after a byte arrives, or after the read-strobe rise has passed the synchronisers. A wrong timeout or spacing counter only shows at the window boundary. Those checks are therefore sampled well inside and well outside each window, and status bit 6 is read during the spacing window. Sweeps over all 256 byte values on the receive, read-back and write paths expose any dropped or swapped data bit.

// File: rtl/hp_pkg.sv
`timescale 1ns/1ps
package hp_pkg;

    typedef enum logic [1:0] {
        PS_SYNTH = 2'd0,
        PS_UART  = 2'd1,
        PS_DEAD  = 2'd2
    } port_state_e;

    localparam logic [7:0] CMD_OPEN  = 8'h3F;
    localparam logic [7:0] CMD_CLOSE = 8'hFF;
    localparam int SYNC_STAGES = 2;

    typedef struct packed {
        logic       a;
        logic       cs_n;
        logic       rd_n;
        logic       wr_n;
        logic [7:0] d;
    } bus_pins_t;

    localparam int PINS_W = $bits(bus_pins_t);
    localparam bus_pins_t PINS_IDLE = '{a: 1'b0, cs_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1, d: 8'h00};

    typedef struct packed {
        logic       wr_ev;
        logic       rd_ev;
        logic       sel_ctrl;
        logic [7:0] wdata;
    } bus_event_t;

    function automatic logic [7:0] make_status(input logic ready, input logic busy);
        return {~ready, busy, 6'h3F};
    endfunction

endpackage

// File: rtl/hp_sync.sv
`timescale 1ns/1ps
module hp_sync #(
    parameter int W = 8,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q[i] <= RST_VAL;
            end else if (i == 0) begin
                stage_q[i] <= din;
            end else begin
                stage_q[i] <= stage_q[(i == 0) ? 0 : i - 1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/hp_bus_decode.sv
`timescale 1ns/1ps
module hp_bus_decode
    import hp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bus_pins_t  pins_s,
    output bus_event_t ev,
    output logic       read_active,
    output logic       read_ctrl
);
    bus_pins_t prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= PINS_IDLE;
        end else begin
            prev_q <= pins_s;
        end
    end

    always_comb begin
        ev.wr_ev    = pins_s.wr_n & ~prev_q.wr_n & ~prev_q.cs_n;
        ev.rd_ev    = pins_s.rd_n & ~prev_q.rd_n & ~prev_q.cs_n;
        ev.sel_ctrl = prev_q.a;
        ev.wdata    = prev_q.d;
    end

    assign read_active = ~pins_s.cs_n & ~pins_s.rd_n;
    assign read_ctrl   = pins_s.a;
endmodule

// File: rtl/hp_core.sv
`timescale 1ns/1ps
module hp_core
    import hp_pkg::*;
#(
    parameter int TIMEOUT_CYC = 9600,
    parameter int MIN_GAP     = 34
) (
    input  logic        clk,
    input  logic        rst,
    input  bus_event_t  ev,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    output port_state_e state,
    output logic        pending,
    output logic [7:0]  data_reg,
    output logic        busy,
    output logic        hdata_valid,
    output logic [7:0]  hdata_byte,
    output logic        wr_too_fast
);
    localparam int AGE_W = $clog2(TIMEOUT_CYC + 1);
    localparam int GAP_W = $clog2(MIN_GAP + 1);
    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(TIMEOUT_CYC - 1);
    localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(MIN_GAP);

    port_state_e      state_q, state_d;
    logic             pend_q;
    logic [7:0]       data_q;
    logic [AGE_W-1:0] age_q;
    logic [GAP_W-1:0] gap_q;
    logic             accept, rejected, rx_take, consume, timeout_hit;

    assign accept      = ev.wr_ev && (gap_q == '0);
    assign rejected    = ev.wr_ev && (gap_q != '0);
    assign rx_take     = rx_valid && (state_q == PS_UART);
    assign consume     = ev.rd_ev && !ev.sel_ctrl && (state_q == PS_UART);
    assign timeout_hit = pend_q && !rx_take && (state_q == PS_UART) && (age_q == AGE_MAX);

    always_comb begin
        state_d = state_q;
        if (accept && ev.sel_ctrl) begin
            case (state_q)
                PS_SYNTH: if (ev.wdata == CMD_OPEN)  state_d = PS_UART;
                PS_UART:  if (ev.wdata == CMD_CLOSE) state_d = PS_SYNTH;
                PS_DEAD:  if (ev.wdata == CMD_CLOSE) state_d = PS_SYNTH;
                default:  state_d = PS_SYNTH;
            endcase
        end else if (timeout_hit) begin
            state_d = PS_DEAD;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_SYNTH;
            pend_q  <= 1'b0;
            data_q  <= 8'h00;
            age_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != PS_UART) begin
                pend_q <= 1'b0;
            end else if (rx_take) begin
                pend_q <= 1'b1;
                data_q <= rx_byte;
            end else if (consume) begin
                pend_q <= 1'b0;
            end
            if (state_d != PS_UART || rx_take || consume || !pend_q) begin
                age_q <= '0;
            end else if (age_q != AGE_MAX) begin
                age_q <= age_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q       <= '0;
            hdata_valid <= 1'b0;
            hdata_byte  <= 8'h00;
            wr_too_fast <= 1'b0;
        end else begin
            if (accept) begin
                gap_q <= GAP_LOAD;
            end else if (gap_q != '0) begin
                gap_q <= gap_q - 1'b1;
            end
            hdata_valid <= accept && !ev.sel_ctrl && (state_q != PS_DEAD);
            if (accept && !ev.sel_ctrl) begin
                hdata_byte <= ev.wdata;
            end
            wr_too_fast <= rejected;
        end
    end

    assign state    = state_q;
    assign pending  = pend_q;
    assign data_reg = data_q;
    assign busy     = (gap_q != '0);
endmodule

// File: rtl/midi_host_port.sv
`timescale 1ns/1ps
module midi_host_port
    import hp_pkg::*;
#(
    parameter int TIMEOUT_CYC = 9600,
    parameter int MIN_GAP     = 34
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_a,
    input  logic       bus_cs_n,
    input  logic       bus_rd_n,
    input  logic       bus_wr_n,
    input  logic [7:0] bus_din,
    output logic [7:0] bus_dout,
    output logic       bus_doe,
    output logic       irq,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    output logic       synth_valid,
    output logic [7:0] synth_byte,
    output logic       hdata_valid,
    output logic [7:0] hdata_byte,
    output logic       uart_mode,
    output logic       wr_too_fast
);
    bus_pins_t   pins_raw, pins_s;
    bus_event_t  bus_ev;
    port_state_e state;
    logic        pending, busy, read_active, read_ctrl;
    logic [7:0]  data_reg;
    logic        ev_wr, ev_rd, ev_ctrl;

    assign pins_raw = '{a: bus_a, cs_n: bus_cs_n, rd_n: bus_rd_n, wr_n: bus_wr_n, d: bus_din};

    hp_sync #(
        .W      (PINS_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PINS_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .din (pins_raw),
        .dout(pins_s)
    );

    hp_bus_decode u_dec (
        .clk        (clk),
        .rst        (rst),
        .pins_s     (pins_s),
        .ev         (bus_ev),
        .read_active(read_active),
        .read_ctrl  (read_ctrl)
    );

    hp_core #(
        .TIMEOUT_CYC(TIMEOUT_CYC),
        .MIN_GAP    (MIN_GAP)
    ) u_core (
        .clk        (clk),
        .rst        (rst),
        .ev         (bus_ev),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .state      (state),
        .pending    (pending),
        .data_reg   (data_reg),
        .busy       (busy),
        .hdata_valid(hdata_valid),
        .hdata_byte (hdata_byte),
        .wr_too_fast(wr_too_fast)
    );

    assign ev_wr   = bus_ev.wr_ev;
    assign ev_rd   = bus_ev.rd_ev;
    assign ev_ctrl = bus_ev.sel_ctrl;

    assign uart_mode   = (state == PS_UART);
    assign irq         = pending && (state == PS_UART);
    assign synth_valid = rx_valid && (state != PS_UART);
    assign synth_byte  = rx_byte;
    assign bus_doe     = read_active;

    always_comb begin
        if (read_ctrl) begin
            bus_dout = make_status(irq, busy);
        end else if (state == PS_DEAD) begin
            bus_dout = 8'h00;
        end else begin
            bus_dout = data_reg;
        end
    end
endmodule

// File: rtl/hp_checker.sv
`timescale 1ns/1ps
module hp_checker (
    input logic clk,
    input logic rst,
    input logic irq,
    input logic uart_mode,
    input logic rx_valid,
    input logic bus_doe,
    input logic bus_cs_n,
    input logic bus_rd_n,
    input logic hdata_valid,
    input logic wr_too_fast,
    input logic ev_wr,
    input logic ev_rd,
    input logic ev_ctrl
);
    // R4
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (uart_mode && rx_valid && !ev_wr) |=> irq);

    // R5
    consume_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && ev_rd && !ev_ctrl && !rx_valid) |=> !irq);

    // R6
    hdata_src_chk: assert property (@(posedge clk) disable iff (rst)
        hdata_valid |-> $past(ev_wr && !ev_ctrl));

    // R10
    fast_drop_chk: assert property (@(posedge clk) disable iff (rst)
        wr_too_fast |-> !hdata_valid);

    // R11
    doe_src_chk: assert property (@(posedge clk) disable iff (rst)
        bus_doe |-> $past(!bus_cs_n && !bus_rd_n, 2));
endmodule

bind midi_host_port hp_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .irq        (irq),
    .uart_mode  (uart_mode),
    .rx_valid   (rx_valid),
    .bus_doe    (bus_doe),
    .bus_cs_n   (bus_cs_n),
    .bus_rd_n   (bus_rd_n),
    .hdata_valid(hdata_valid),
    .wr_too_fast(wr_too_fast),
    .ev_wr      (ev_wr),
    .ev_rd      (ev_rd),
    .ev_ctrl    (ev_ctrl)
);

// File: tb/midi_host_port_test.sv
`timescale 1ns/1ps
module midi_host_port_test;
    localparam int TMO = 40;
    localparam int GAP = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_a = 1'b0, bus_cs_n = 1'b1, bus_rd_n = 1'b1, bus_wr_n = 1'b1;
    logic [7:0] bus_din = 8'h00;
    logic [7:0] bus_dout;
    logic       bus_doe, irq;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       synth_valid, hdata_valid, uart_mode, wr_too_fast;
    logic [7:0] synth_byte, hdata_byte;

    int total = 0;
    int bad = 0;
    int hd_cnt = 0;
    int fast_cnt = 0;
    logic [7:0] last_hd = 8'h00;
    bit done = 0;

    always #10 clk = ~clk;

    midi_host_port #(.TIMEOUT_CYC(TMO), .MIN_GAP(GAP)) uut (
        .clk(clk), .rst(rst), .bus_a(bus_a), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
        .bus_wr_n(bus_wr_n), .bus_din(bus_din), .bus_dout(bus_dout), .bus_doe(bus_doe),
        .irq(irq), .rx_valid(rx_valid), .rx_byte(rx_byte), .synth_valid(synth_valid),
        .synth_byte(synth_byte), .hdata_valid(hdata_valid), .hdata_byte(hdata_byte),
        .uart_mode(uart_mode), .wr_too_fast(wr_too_fast)
    );

    always @(posedge clk) begin
        if (!rst && hdata_valid) begin
            hd_cnt  <= hd_cnt + 1;
            last_hd <= hdata_byte;
        end
        if (!rst && wr_too_fast) fast_cnt <= fast_cnt + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(input logic sel, input logic [7:0] v, input int idle, input logic use_cs);
        @(negedge clk);
        bus_a = sel; bus_din = v; bus_cs_n = ~use_cs;
        cyc(3); bus_wr_n = 1'b0;
        cyc(3); bus_wr_n = 1'b1;
        cyc(3); bus_cs_n = 1'b1;
        cyc(idle);
    endtask

    task automatic host_read(input logic sel, output logic [7:0] v, output logic oe);
        @(negedge clk);
        bus_a = sel; bus_cs_n = 1'b0;
        cyc(2); bus_rd_n = 1'b0;
        cyc(4); v = bus_dout; oe = bus_doe;
        bus_rd_n = 1'b1;
        cyc(3); bus_cs_n = 1'b1;
        cyc(3);
    endtask

    task automatic push_rx(input logic [7:0] v);
        @(negedge clk);
        rx_byte = v; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic oe;
        int base;
        cyc(5);
        rst = 1'b0;
        cyc(4);

        // R1 reset state
        chk("R1 irq", irq, 0);
        chk("R1 uart_mode", uart_mode, 0);
        chk("R1 doe", bus_doe, 0);
        host_read(1'b1, v, oe);
        chk("R1 status", v, 8'hBF);

        // R3 synthesizer routing sweep
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            rx_byte = 8'(i); rx_valid = 1'b1;
            #1;
            chk("R3 synth_valid", synth_valid, 1);
            chk("R3 synth_byte", synth_byte, i);
        end
        @(negedge clk); rx_valid = 1'b0;
        cyc(2);
        chk("R3 irq stays low", irq, 0);

        // R6 data write sweep
        for (int i = 0; i < 256; i++) begin
            base = hd_cnt;
            host_write(1'b0, 8'(i), 25, 1'b1);
            chk("R6 pulse count", hd_cnt - base, 1);
            chk("R6 byte", last_hd, i);
        end

        // R7 chip select high ignored
        base = hd_cnt;
        host_write(1'b0, 8'hA5, 25, 1'b0);
        chk("R7 no data pulse", hd_cnt - base, 0);
        host_write(1'b1, 8'h3F, 25, 1'b0);
        chk("R7 no mode change", uart_mode, 0);

        // R11 read strobe with chip select high
        @(negedge clk); bus_rd_n = 1'b0;
        cyc(4);
        chk("R11 doe with cs high", bus_doe, 0);
        bus_rd_n = 1'b1;
        cyc(3);

        // R10 spacing window
        host_write(1'b0, 8'h11, 0, 1'b1);
        host_read(1'b1, v, oe);
        chk("R10 busy status", v, 8'hFF);
        chk("R11 doe during read", oe, 1);
        chk("R11 doe after read", bus_doe, 0);
        cyc(30);
        host_read(1'b1, v, oe);
        chk("R10 idle status", v, 8'hBF);
        base = fast_cnt;
        host_write(1'b0, 8'h33, 0, 1'b1);
        host_write(1'b0, 8'h22, 30, 1'b1);
        chk("R10 too fast flagged", fast_cnt - base, 1);
        chk("R10 dropped write", last_hd, 8'h33);

        // R2 enter host mode
        host_write(1'b1, 8'h3F, 25, 1'b1);
        chk("R2 uart_mode set", uart_mode, 1);
        @(negedge clk); rx_byte = 8'h5A; rx_valid = 1'b1;
        #1;
        chk("R3 no synth in host mode", synth_valid, 0);
        @(negedge clk); rx_valid = 1'b0;
        host_read(1'b0, v, oe);
        cyc(2);

        // R4 / R5 sweep
        for (int i = 0; i < 256; i++) begin
            push_rx(8'(i));
            chk("R4 irq raised", irq, 1);
            host_read(1'b1, v, oe);
            chk("R4 status ready", v, 8'h3F);
            chk("R5 status read keeps irq", irq, 1);
            host_read(1'b0, v, oe);
            chk("R4 data byte", v, i);
            chk("R5 irq cleared", irq, 0);
        end
        host_read(1'b1, v, oe);
        chk("R5 status empty", v, 8'hBF);

        // R2 close back to synthesizer
        host_write(1'b1, 8'hFF, 25, 1'b1);
        chk("R2 uart_mode cleared", uart_mode, 0);
        host_write(1'b1, 8'h3F, 25, 1'b1);
        chk("R2 reopen", uart_mode, 1);

        // R8 timeout
        push_rx(8'hC3);
        cyc(TMO - 12);
        chk("R8 irq before timeout", irq, 1);
        cyc(20);
        chk("R8 irq forced low", irq, 0);
        chk("R8 uart_mode low", uart_mode, 0);
        host_read(1'b0, v, oe);
        chk("R8 data reads zero", v, 8'h00);
        host_read(1'b1, v, oe);
        chk("R8 status", v, 8'hBF);
        base = hd_cnt;
        host_write(1'b0, 8'h77, 25, 1'b1);
        chk("R8 data write not forwarded", hd_cnt - base, 0);
        push_rx(8'h44);
        chk("R8 irq stays low", irq, 0);

        // R9 reopen sequence
        host_write(1'b1, 8'h3F, 25, 1'b1);
        chk("R9 open alone ignored", uart_mode, 0);
        host_write(1'b1, 8'hFF, 25, 1'b1);
        chk("R9 after close", uart_mode, 0);
        host_write(1'b1, 8'h3F, 25, 1'b1);
        chk("R9 reopened", uart_mode, 1);
        push_rx(8'h96);
        chk("R9 irq works", irq, 1);
        host_read(1'b0, v, oe);
        chk("R9 data byte", v, 8'h96);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule